// File: doc/BRIEF.md
# Bus-to-ISA I/O Window Translator

This block sits between a big-endian processor bus and a little-endian ISA-style I/O port space. The processor reaches I/O devices through an 8 MB address window at 0x80000000. Each request inside that window becomes one port access on the downstream side. Requests outside the window are left alone, so a neighbouring decoder can claim them.

The port number comes from the window address in one of two ways, chosen by a map-mode input.
- In dense mode, the port is simply the low sixteen address bits.
- In sparse mode, each 4 KB page of the window carries 32 ports. The page index and the five low offset bits are packed together into one port number.

Halfword and word data cross the endian boundary with their bytes reversed. Byte data is not swapped.

A three-state controller sequences each transfer:
- **IDLE**: waits for a claimable request. Transition *accept* goes to ISSUE.
- **ISSUE**: drives the downstream request. Transition *wait* stays in ISSUE while no acknowledge arrives. Transition *ack* goes to RESP.
- **RESP**: pulses the completion flag. Transition *retire* returns to IDLE unconditionally.

Top module: `isa_io_window_bridge`

## Requirements
- R1: `cpu_accept` is high only in a cycle where `cpu_valid` is high, the controller is idle, and `cpu_addr` is within 0x80000000..0x807FFFFF. Any other address is never accepted and raises no `io_req`.
- R2: With `map_mode` = 0 (dense), `io_port` equals `cpu_addr[15:0]`.
- R3: With `map_mode` = 1 (sparse), `io_port` equals `{cpu_addr[22:12], cpu_addr[4:0]}`. This is the low five bits OR-ed with address bits 22..12 moved down by seven places.
- R4: A byte access (`cpu_size` = 2'b00) is not swapped.
  - A write drives `io_wdata` = `{24'h0, cpu_wdata[7:0]}`.
  - A read returns `{24'h0, io_rdata[7:0]}`.
- R5: A halfword access (`cpu_size` = 2'b01) swaps its two bytes in both directions.
  - A write drives `{16'h0, cpu_wdata[7:0], cpu_wdata[15:8]}`.
  - A read returns `{16'h0, io_rdata[7:0], io_rdata[15:8]}`.
- R6: A word access (`cpu_size` = 2'b10, and the reserved code 2'b11) reverses all four bytes in both directions.
- R7: From the cycle after acceptance, `io_req` stays high until the cycle in which `io_ack` is seen. During that time the following stay constant:
  - `io_port`
  - `io_wdata`
  - `io_size`, which equals the accepted size
  - `io_write`, which equals the accepted write flag

  `io_wdata` is zero for reads.
- R8: `map_mode` is sampled only at acceptance. Changing it while a transfer is in flight does not alter `io_port`.
- R9: `cpu_done` is a one-cycle pulse in the cycle after `io_ack` is seen.
  - For a read, `cpu_rdata` then holds the swapped read data.
  - For a write, `cpu_rdata` is zero.
- R10: After reset the following are all zero: `io_req`, `cpu_done`, `cpu_rdata`, `io_port`. The controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| map_mode | input | 1 | 0 = dense port map, 1 = sparse page-packed map |
| cpu_valid | input | 1 | Processor request present |
| cpu_addr | input | 32 | Processor byte address |
| cpu_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_wdata | input | 32 | Write data, right-aligned, big-endian value |
| cpu_accept | output | 1 | Request claimed this cycle |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Swapped, zero-extended read data |
| io_req | output | 1 | Downstream port access pending |
| io_port | output | 16 | Downstream port number |
| io_size | output | 2 | Downstream access size, same code as cpu_size |
| io_write | output | 1 | Downstream write flag |
| io_wdata | output | 32 | Little-endian write data |
| io_ack | input | 1 | Downstream access finished |
| io_rdata | input | 32 | Downstream read data, low lanes significant |

## Verification
A wrong controller state shows at the ports within one cycle:
- `io_req` dropping before `io_ack`
- a missing or doubled `cpu_done` pulse
- `cpu_accept` rising while a transfer is still open

A corrupted latched port or size shows as a wrong `io_port` or a wrong lane order in the first cycle of ISSUE. The bench flips `map_mode` right after every acceptance. A port latch that follows the live mode input therefore shows a changed `io_port` on the next sample.

// File: rtl/isa_win_pkg.sv
package isa_win_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_ISSUE = 2'b01,
        ST_RESP  = 2'b10
    } xfer_state_e;

endpackage

// File: rtl/isa_win_decode.sv
module isa_win_decode #(
    parameter int          ADDR_W     = 32,
    parameter int          PORT_W     = 16,
    parameter int          WIN_BITS   = 23,
    parameter int          PAGE_SHIFT = 12,
    parameter int          LOW_BITS   = 5,
    parameter logic [31:0] WIN_BASE   = 32'h8000_0000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              sparse,
    output logic              hit,
    output logic [PORT_W-1:0] port
);
    localparam int PAGE_W = WIN_BITS - PAGE_SHIFT;
    localparam int FOLD_W = PAGE_W + LOW_BITS;

    logic [FOLD_W-1:0] folded;
    logic [PORT_W-1:0] dense_port;
    logic [PORT_W-1:0] sparse_port;

    // Window hit: every address bit above the window size must match the base.
    assign hit = (addr[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS]);

    // Dense map: the low port-width bits of the address.
    assign dense_port = addr[PORT_W-1:0];

    // Sparse map: the page index sits directly above the in-page low bits.
    assign folded      = {addr[WIN_BITS-1:PAGE_SHIFT], addr[LOW_BITS-1:0]};
    assign sparse_port = PORT_W'(folded);

    assign port = sparse ? sparse_port : dense_port;

endmodule

// File: rtl/isa_win_lane_swap.sv
module isa_win_lane_swap
    import isa_win_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] din,
    input  acc_size_e         size,
    output logic [DATA_W-1:0] dout
);
    localparam int NBYTES = DATA_W / 8;

    logic [DATA_W-1:0] v_byte;
    logic [DATA_W-1:0] v_half;
    logic [DATA_W-1:0] v_word;

    // One lane of each size variant per generated slice.
    // Lanes beyond the access width are zero.
    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        if (g == 0) begin : g_b0
            assign v_byte[8*g +: 8] = din[7:0];
        end else begin : g_bz
            assign v_byte[8*g +: 8] = 8'h00;
        end

        if (g < 2) begin : g_hs
            assign v_half[8*g +: 8] = din[8*(1-g) +: 8];
        end else begin : g_hz
            assign v_half[8*g +: 8] = 8'h00;
        end

        assign v_word[8*g +: 8] = din[8*(NBYTES-1-g) +: 8];
    end

    always_comb begin
        unique case (size)
            SZ_BYTE: dout = v_byte;
            SZ_HALF: dout = v_half;
            default: dout = v_word;
        endcase
    end

endmodule

// File: rtl/isa_win_ctrl.sv
module isa_win_ctrl
    import isa_win_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        io_ack,
    output xfer_state_e state,
    output logic        idle,
    output logic        io_req,
    output logic        done,
    output logic        capture
);
    xfer_state_e nxt;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Transitions: accept, wait, ack, retire
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start)  nxt = ST_ISSUE;
            ST_ISSUE: if (io_ack) nxt = ST_RESP;
            ST_RESP:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        idle    = 1'b0;
        io_req  = 1'b0;
        done    = 1'b0;
        capture = 1'b0;
        unique case (state)
            ST_IDLE:  idle = 1'b1;
            ST_ISSUE: begin
                io_req  = 1'b1;
                capture = io_ack;
            end
            ST_RESP:  done = 1'b1;
            default:  idle = 1'b0;
        endcase
    end

    // R7: the downstream request is held until acknowledged
    a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ISSUE && !io_ack) |=> (state == ST_ISSUE));

    // R9: completion follows one cycle after the acknowledge
    a_r9_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && io_ack) |=> done);

    // R9: completion is a single-cycle pulse
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/isa_io_window_bridge.sv
module isa_io_window_bridge
    import isa_win_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          DATA_W     = 32,
    parameter int          PORT_W     = 16,
    parameter int          WIN_BITS   = 23,
    parameter int          PAGE_SHIFT = 12,
    parameter int          LOW_BITS   = 5,
    parameter logic [31:0] WIN_BASE   = 32'h8000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_mode,
    input  logic              cpu_valid,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [1:0]        cpu_size,
    input  logic              cpu_write,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_accept,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              io_req,
    output logic [PORT_W-1:0] io_port,
    output logic [1:0]        io_size,
    output logic              io_write,
    output logic [DATA_W-1:0] io_wdata,
    input  logic              io_ack,
    input  logic [DATA_W-1:0] io_rdata
);
    xfer_state_e       state;
    logic              idle;
    logic              capture;
    logic              hit;
    logic [PORT_W-1:0] port_calc;
    logic [DATA_W-1:0] wr_swapped;
    logic [DATA_W-1:0] rd_swapped;
    acc_size_e         size_q;

    isa_win_decode #(
        .ADDR_W     (ADDR_W),
        .PORT_W     (PORT_W),
        .WIN_BITS   (WIN_BITS),
        .PAGE_SHIFT (PAGE_SHIFT),
        .LOW_BITS   (LOW_BITS),
        .WIN_BASE   (WIN_BASE)
    ) u_decode (
        .addr   (cpu_addr),
        .sparse (map_mode),
        .hit    (hit),
        .port   (port_calc)
    );

    isa_win_lane_swap #(.DATA_W(DATA_W)) u_swap_wr (
        .din  (cpu_wdata),
        .size (acc_size_e'(cpu_size)),
        .dout (wr_swapped)
    );

    isa_win_lane_swap #(.DATA_W(DATA_W)) u_swap_rd (
        .din  (io_rdata),
        .size (size_q),
        .dout (rd_swapped)
    );

    isa_win_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (cpu_accept),
        .io_ack  (io_ack),
        .state   (state),
        .idle    (idle),
        .io_req  (io_req),
        .done    (cpu_done),
        .capture (capture)
    );

    assign cpu_accept = cpu_valid && hit && idle;
    assign io_size    = size_q;

    // Request latch: port, size and data are frozen at acceptance (R8)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_port  <= '0;
            size_q   <= SZ_BYTE;
            io_write <= 1'b0;
            io_wdata <= '0;
        end else if (cpu_accept) begin
            io_port  <= port_calc;
            size_q   <= acc_size_e'(cpu_size);
            io_write <= cpu_write;
            io_wdata <= cpu_write ? wr_swapped : '0;
        end
    end

    // Response latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_rdata <= '0;
        end else if (capture) begin
            cpu_rdata <= io_write ? '0 : rd_swapped;
        end
    end

    // R1: nothing is claimed while a transfer is open
    a_r1_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req || cpu_done) |-> !cpu_accept);

    // R1: a claimed address always lies in the window
    a_r1_claim_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_accept |-> (cpu_addr[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS]));

    // R7, R8: the pending access does not change while waiting
    a_r8_port_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && !io_ack) |=> ($stable(io_port) && $stable(io_wdata) && $stable(io_size)));

    // R10: the controller state is a legal encoding
    a_r10_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({state == ST_ISSUE, state == ST_RESP}) && (state != 2'b11));

endmodule

// File: tb/isa_io_window_bridge_tb.sv
module isa_io_window_bridge_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        map_mode;
    logic        cpu_valid;
    logic [31:0] cpu_addr;
    logic [1:0]  cpu_size;
    logic        cpu_write;
    logic [31:0] cpu_wdata;
    logic        cpu_accept;
    logic        cpu_done;
    logic [31:0] cpu_rdata;
    logic        io_req;
    logic [15:0] io_port;
    logic [1:0]  io_size;
    logic        io_write;
    logic [31:0] io_wdata;
    logic        io_ack;
    logic [31:0] io_rdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    isa_io_window_bridge u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .map_mode   (map_mode),
        .cpu_valid  (cpu_valid),
        .cpu_addr   (cpu_addr),
        .cpu_size   (cpu_size),
        .cpu_write  (cpu_write),
        .cpu_wdata  (cpu_wdata),
        .cpu_accept (cpu_accept),
        .cpu_done   (cpu_done),
        .cpu_rdata  (cpu_rdata),
        .io_req     (io_req),
        .io_port    (io_port),
        .io_size    (io_size),
        .io_write   (io_write),
        .io_wdata   (io_wdata),
        .io_ack     (io_ack),
        .io_rdata   (io_rdata)
    );

    typedef struct packed {
        logic        mode;
        logic [31:0] addr;
        logic [1:0]  size;
        logic        wr;
        logic [31:0] wdata;
        logic [31:0] iord;
        logic [15:0] port;
        logic [31:0] exp_wd;
        logic [31:0] exp_rd;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'h8000_1234, 2'b00, 1'b1, 32'hAABB_CC5A, 32'h0,          16'h1234, 32'h0000_005A, 32'h0},
        '{1'b0, 32'h807F_F3F8, 2'b00, 1'b0, 32'h0,          32'h1234_56C3, 16'hF3F8, 32'h0,          32'h0000_00C3},
        '{1'b0, 32'h800A_0170, 2'b01, 1'b1, 32'h9999_1122, 32'h0,          16'h0170, 32'h0000_2211, 32'h0},
        '{1'b0, 32'h8000_01F0, 2'b01, 1'b0, 32'h0,          32'hFFFF_ABCD, 16'h01F0, 32'h0,          32'h0000_CDAB},
        '{1'b1, 32'h8012_3445, 2'b10, 1'b1, 32'h1122_3344, 32'h0,          16'h2465, 32'h4433_2211, 32'h0},
        '{1'b1, 32'h807F_FFFF, 2'b10, 1'b0, 32'h0,          32'hDEAD_BEEF, 16'hFFFF, 32'h0,          32'hEFBE_ADDE},
        '{1'b1, 32'h8000_0398, 2'b00, 1'b0, 32'h0,          32'h0000_00A5, 16'h0018, 32'h0,          32'h0000_00A5},
        '{1'b0, 32'h807F_FFFE, 2'b01, 1'b1, 32'h0000_BEEF, 32'h0,          16'hFFFE, 32'h0000_EFBE, 32'h0},
        '{1'b1, 32'h8005_5060, 2'b01, 1'b0, 32'h0,          32'h0000_3412, 16'h0AA0, 32'h0,          32'h0000_1234},
        '{1'b0, 32'h8000_0000, 2'b11, 1'b1, 32'h0102_0304, 32'h0,          16'h0000, 32'h0403_0201, 32'h0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG_LIMIT && !finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, WDOG_LIMIT);
            finish_run();
        end
    end

    task automatic run_vec(input vec_t v, input int waits);
        @(negedge clk);
        map_mode  = v.mode;
        cpu_valid = 1'b1;
        cpu_addr  = v.addr;
        cpu_size  = v.size;
        cpu_write = v.wr;
        cpu_wdata = v.wdata;
        #1;
        chk("R1 accept in window", 32'(cpu_accept), 32'd1);
        @(negedge clk);
        cpu_valid = 1'b0;
        map_mode  = ~v.mode;           // R8: flip after acceptance
        cpu_addr  = 32'h0;
        #1;
        chk("R7 io_req raised", 32'(io_req), 32'd1);
        chk(v.mode ? "R3 sparse port" : "R2 dense port", 32'(io_port), 32'(v.port));
        chk("R4/R5/R6 write lanes", io_wdata, v.exp_wd);
        chk("R7 size", 32'(io_size), 32'(v.size));
        chk("R7 write flag", 32'(io_write), 32'(v.wr));
        for (int w = 0; w < waits; w++) begin
            @(negedge clk);
            #1;
            chk("R7 request held", 32'(io_req), 32'd1);
            chk("R8 port unchanged by mode", 32'(io_port), 32'(v.port));
        end
        @(negedge clk);
        io_ack   = 1'b1;
        io_rdata = v.iord;
        @(negedge clk);
        io_ack   = 1'b0;
        io_rdata = 32'h0;
        #1;
        chk("R9 done pulse", 32'(cpu_done), 32'd1);
        chk("R9 request dropped", 32'(io_req), 32'd0);
        chk("R4/R5/R6/R9 read data", cpu_rdata, v.exp_rd);
        @(negedge clk);
        #1;
        chk("R9 done single cycle", 32'(cpu_done), 32'd0);
    endtask

    task automatic miss(input logic [31:0] a);
        @(negedge clk);
        cpu_valid = 1'b1;
        cpu_addr  = a;
        cpu_size  = 2'b10;
        cpu_write = 1'b0;
        #1;
        chk("R1 out of window not accepted", 32'(cpu_accept), 32'd0);
        @(negedge clk);
        cpu_valid = 1'b0;
        #1;
        chk("R1 no io_req for miss", 32'(io_req), 32'd0);
    endtask

    initial begin
        rst_n     = 1'b0;
        map_mode  = 1'b0;
        cpu_valid = 1'b0;
        cpu_addr  = 32'h0;
        cpu_size  = 2'b00;
        cpu_write = 1'b0;
        cpu_wdata = 32'h0;
        io_ack    = 1'b0;
        io_rdata  = 32'h0;
        repeat (3) @(negedge clk);
        #1;
        // R10: reset state
        chk("R10 io_req reset", 32'(io_req), 32'd0);
        chk("R10 done reset", 32'(cpu_done), 32'd0);
        chk("R10 rdata reset", cpu_rdata, 32'h0);
        chk("R10 port reset", 32'(io_port), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) run_vec(VECS[i], i % 3);

        // R1: addresses just outside the window and far away
        miss(32'h7FFF_FFFC);
        miss(32'h8080_0000);
        miss(32'h0000_1000);

        // R1: valid low with an in-window address
        @(negedge clk);
        cpu_valid = 1'b0;
        cpu_addr  = 32'h8000_0010;
        #1;
        chk("R1 no accept without valid", 32'(cpu_accept), 32'd0);

        // R1: a second request while busy is not claimed
        @(negedge clk);
        cpu_valid = 1'b1;
        cpu_addr  = 32'h8000_0020;
        cpu_size  = 2'b00;
        cpu_write = 1'b1;
        cpu_wdata = 32'h77;
        map_mode  = 1'b0;
        @(negedge clk);
        cpu_addr  = 32'h8000_0040;
        #1;
        chk("R1 busy blocks accept", 32'(cpu_accept), 32'd0);
        chk("R2 first port kept", 32'(io_port), 32'h0020);
        cpu_valid = 1'b0;
        io_ack    = 1'b1;
        @(negedge clk);
        io_ack    = 1'b0;
        #1;
        chk("R9 write done", 32'(cpu_done), 32'd1);
        chk("R9 write returns zero", cpu_rdata, 32'h0);
        @(negedge clk);

        // R10: reset in the middle of a transfer
        cpu_valid = 1'b1;
        cpu_addr  = 32'h8000_0300;
        @(negedge clk);
        cpu_valid = 1'b0;
        rst_n     = 1'b0;
        @(negedge clk);
        #1;
        chk("R10 reset clears request", 32'(io_req), 32'd0);
        chk("R10 reset clears port", 32'(io_port), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        finish_run();
    end

endmodule